// File: doc/BRIEF.md
# Period and Duty Pulse-Width Modulator

This block produces one pulse-width modulated output from a timebase that is prescaled by four. An 8-bit period value sets how many timer steps make up one cycle. Because each timer step spans four clocks, a cycle lasts (period + 1) * 4 clocks, so a larger period gives a longer cycle and a lower output frequency. A 10-bit duty value sets the high time in single clocks. The duty value is compared against the timer count extended by the two prescaler bits, so the duty is four times finer than the period.

Software-side logic loads the two values over a plain write-enable bus with a one-bit register select. Each write lands in a holding register. The counting logic copies both holding registers into the working registers only when a new cycle begins, so a cycle already under way always finishes with the values it started with. The output rises at the start of each cycle and falls when the extended count reaches the duty value. A duty of zero keeps the output low. A duty of one full cycle or more keeps it high. A short period leaves fewer clocks in a cycle, and therefore fewer distinct duty levels. A one-clock marker output flags the first clock of every cycle.

Top module: `pwm_gen`

## Requirements
- R1: With a working period P, one cycle lasts exactly (P+1)*4 clocks, measured from one `frame_o` pulse to the next.
- R2: For a working duty D with 0 < D < (P+1)*4, `pwm_o` is high in the first D clocks of the cycle and low in the remaining clocks.
- R3: A working duty of 0 holds `pwm_o` low for the whole cycle.
- R4: A working duty of (P+1)*4 or more holds `pwm_o` high for the whole cycle, with no transitions.
- R5: Writes change only the holding registers. A value written during a cycle has no effect on that cycle. It becomes the working value at the first cycle start that follows the write clock edge.
- R6: `frame_o` is high for exactly one clock per cycle. That clock is the one in which the extended count is zero.
- R7: While `rst_n` is low, the count, the working registers and the holding registers are zero, `pwm_o` is low and `frame_o` is high.
- R8: When `wr_en` is 1, `wr_sel` = 0 writes the period from `wr_data[7:0]` and `wr_sel` = 1 writes the duty from `wr_data[9:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the holding registers |
| wr_sel | input | 1 | Register select: 0 selects period, 1 selects duty |
| wr_data | input | 10 | Write data |
| pwm_o | output | 1 | Registered modulated output |
| frame_o | output | 1 | High in the first clock of each cycle |

## Verification
The assertions assume that the block leaves reset at the start of a cycle. They also assume that the working registers change only when `frame_o` rises, so every cycle can be judged against the period and duty it started with. The cycle-length property assumes that no write lands on the same edge as a cycle boundary. For that reason the stimulus places every write inside a cycle, at a chosen offset that always leaves at least one clock before the boundary. The bench moves that offset from cycle to cycle across a sweep of every duty from 0 up to just past a full cycle, for the six shortest periods, and then for a few long periods.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    SEL_PERIOD = 1'b0,
    SEL_DUTY   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PRE_W-1:0] pre_q,
  output logic [PRE_W-1:0] pre_nx,
  output logic             tick
);
  // Free-running divider; tick marks the last clock of each timer step
  assign pre_nx = pre_q + PRE_W'(1);
  assign tick   = &pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_nx;
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PER_W-1:0] per_act,
  output logic [PER_W-1:0] tmr_q,
  output logic [PER_W-1:0] tmr_nx,
  output logic             wrap
);
  logic at_end;

  assign at_end = (tmr_q == per_act);
  assign wrap   = tick && at_end;

  always_comb begin
    tmr_nx = tmr_q;
    if (tick) tmr_nx = at_end ? '0 : tmr_q + PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_nx;
  end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int PER_W  = 8,
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DUTY_W-1:0] wr_data,
  input  logic              wrap,
  output logic [PER_W-1:0]  per_act,
  output logic [DUTY_W-1:0] duty_act,
  output logic [DUTY_W-1:0] duty_nx
);
  logic [PER_W-1:0]  per_hold;
  logic [DUTY_W-1:0] duty_hold;
  logic [PER_W-1:0]  per_nx;

  // Holding registers: written at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_hold  <= '0;
      duty_hold <= '0;
    end else if (wr_en) begin
      if (reg_sel_e'(wr_sel) == SEL_PERIOD) per_hold  <= wr_data[PER_W-1:0];
      else                                   duty_hold <= wr_data;
    end
  end

  // Working registers: copied only at the cycle boundary
  assign per_nx  = wrap ? per_hold  : per_act;
  assign duty_nx = wrap ? duty_hold : duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act  <= '0;
      duty_act <= '0;
    end else begin
      per_act  <= per_nx;
      duty_act <= duty_nx;
    end
  end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] ext_nx,
  input  logic [DUTY_W-1:0] duty_nx,
  output logic              pwm_q,
  output logic              frame_q
);
  // Registered from next-state values so the pin lines up with the count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q   <= 1'b0;
      frame_q <= 1'b1;
    end else begin
      pwm_q   <= (ext_nx < duty_nx);
      frame_q <= (ext_nx == '0);
    end
  end
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen #(
  parameter int PER_W = 8,
  parameter int PRE_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_sel,
  input  logic [PER_W+PRE_W-1:0] wr_data,
  output logic                   pwm_o,
  output logic                   frame_o
);
  localparam int DUTY_W = PER_W + PRE_W;

  logic [PRE_W-1:0]  pre_q, pre_nx;
  logic              tick, wrap;
  logic [PER_W-1:0]  tmr_q, tmr_nx, per_act;
  logic [DUTY_W-1:0] duty_act, duty_nx, ext_nx;

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .pre_q(pre_q), .pre_nx(pre_nx), .tick(tick)
  );

  pwm_timer #(.PER_W(PER_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .per_act(per_act),
    .tmr_q(tmr_q), .tmr_nx(tmr_nx), .wrap(wrap)
  );

  pwm_regs #(.PER_W(PER_W), .DUTY_W(DUTY_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wrap(wrap), .per_act(per_act),
    .duty_act(duty_act), .duty_nx(duty_nx)
  );

  assign ext_nx = {tmr_nx, pre_nx};

  pwm_compare #(.DUTY_W(DUTY_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .ext_nx(ext_nx), .duty_nx(duty_nx),
    .pwm_q(pwm_o), .frame_q(frame_o)
  );
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int PER_W = 8,
  parameter int PRE_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   frame_o,
  input logic                   pwm_o,
  input logic [PER_W-1:0]       per_act,
  input logic [PER_W+PRE_W-1:0] duty_act
);
  localparam int LEN_W = PER_W + PRE_W + 1;

  logic [LEN_W-1:0] full_len, start_len, gap;
  logic             seen;

  assign full_len = (LEN_W'(per_act) + LEN_W'(1)) << PRE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap       <= '0;
      start_len <= '0;
      seen      <= 1'b0;
    end else if (frame_o) begin
      gap       <= LEN_W'(1);
      start_len <= full_len;
      seen      <= 1'b1;
    end else begin
      gap <= gap + LEN_W'(1);
    end
  end

  AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_o && seen) |-> (gap == start_len)); // R1

  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_o && duty_act != '0) |-> pwm_o); // R2

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> !pwm_o); // R3

  AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (LEN_W'(duty_act) >= full_len) |-> pwm_o); // R4

  AST_HOLD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_o |-> ($stable(per_act) && $stable(duty_act))); // R5
endmodule

bind pwm_gen pwm_gen_chk #(.PER_W(PER_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_o(frame_o), .pwm_o(pwm_o),
  .per_act(per_act), .duty_act(duty_act)
);

// File: tb/pwm_gen_bench.sv
module pwm_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [9:0] wr_data = '0;
  logic       pwm_o, frame_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_gen u_pwm_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_o(pwm_o), .frame_o(frame_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one cycle that starts at the current sample (frame_o seen high).
  // p/d are the values expected to be working; when wr is set, the next
  // values are written at offsets wa and wa+1 (R8: sel 0 period, sel 1 duty).
  task automatic run_cycle(input int p, input int d, input bit wr, input int wa,
                           input int np, input int nd);
    int i = 0;
    int bad_out = 0;
    int bad_frm = 0;
    int lim = (p + 1) * 4;
    int highs = 0;
    string rq;
    do begin
      if (pwm_o !== (i < d)) bad_out++;
      if (pwm_o === 1'b1) highs++;
      if (frame_o !== (i == 0)) bad_frm++;
      wr_en = 1'b0;
      if (wr && i == wa)     begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = 10'(np); end
      if (wr && i == wa + 1) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = 10'(nd); end
      @(negedge clk);
      i++;
    end while (frame_o !== 1'b1 && i < 5000);
    wr_en = 1'b0;
    // Cycle length; values come from a write made in the previous cycle (R5, R8)
    chk(i == lim, "R1 R5 R8 cycle length", i, lim);
    if (d == 0)        rq = "R3 duty zero stays low";
    else if (d >= lim) rq = "R4 full duty stays high";
    else               rq = "R2 high for duty clocks";
    chk(bad_out == 0, rq, highs, (d < lim) ? d : lim);
    chk(bad_frm == 0, "R6 single frame marker", bad_frm, 0);
  endtask

  initial begin
    int pp = 0;
    int pd = 0;
    int k = 0;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(pwm_o === 1'b0, "R7 output low in reset", int'(pwm_o), 0);
    chk(frame_o === 1'b1, "R7 frame high in reset", int'(frame_o), 1);
    rst_n = 1'b1;
    // Sweep every duty past one full cycle for short periods
    for (int p = 0; p < 6; p++) begin
      for (int d = 0; d <= (p + 1) * 4 + 2; d++) begin
        run_cycle(pp, pd, 1'b1, k % ((pp + 1) * 4 - 2), p, d);
        pp = p; pd = d; k++;
      end
    end
    // Long periods and mid-range duties
    run_cycle(pp, pd, 1'b1, 1, 63, 100);   pp = 63;  pd = 100;
    run_cycle(pp, pd, 1'b1, 200, 63, 256); pp = 63;  pd = 256;
    run_cycle(pp, pd, 1'b1, 7, 255, 1023); pp = 255; pd = 1023;
    run_cycle(pp, pd, 1'b1, 900, 255, 0);  pp = 255; pd = 0;
    run_cycle(pp, pd, 1'b1, 3, 2, 5);      pp = 2;   pd = 5;
    run_cycle(pp, pd, 1'b0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule